// File: doc/BRIEF.md
# Time-Slot Interchanger with Selectable Control Mode

This block is a digital time switch for one PCM highway. Each clock cycle carries one time slot. A byte arrives on `din` in each slot, and a pulse on `fsync` marks slot 0 of a frame. A speech store with one byte per slot holds each sample until its destination slot comes round. A connection store of the same depth says where each sample goes. A slot counter, realigned by `fsync`, drives both stores in step with the highway. The switched byte for each slot appears on `dout` one cycle after that slot's input cycle.

The static input `mode_in_assoc` selects one of two ways of working. With it low, samples are stored in slot order, and each output slot reads the speech location named by its own connection word. With it high, the connection word of each input slot names the location that slot's sample is stored in, and output slot j reads location j in turn. A host writes a connection with `host_wr` and removes it with `host_erase`. Any output slot that carries no connection emits the idle byte.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_n` is low at a clock edge, all connection words become invalid and `dout` becomes `IDLE_BYTE` (default 8'hD5). Until the host writes a connection, every output slot carries `IDLE_BYTE`.
- R2: The slot counter steps 0,1,…,SLOTS-1 and wraps to 0 without any `fsync`. A cycle with `fsync` high is slot 0, whatever the count was.
- R3: In the output-associated mode (`mode_in_assoc`=0), the input byte of slot k is stored at location k. `host_wr` with `host_loc`=j and `host_word`=k connects input slot k to output slot j. When j>k, the byte leaves in the same frame, j-k slots later.
- R4: In the input-associated mode (`mode_in_assoc`=1), `host_wr` with `host_loc`=k and `host_word`=j stores the input byte of slot k at location j. Location j is read during output slot j. When j>k, the byte leaves in the same frame.
- R5: When the destination slot is at or before the source slot, the byte leaves in the next frame. In a same-slot connection the read comes before the write, so output slot k carries the byte of input slot k from the previous frame.
- R6: An output slot with no valid connection emits `IDLE_BYTE`. In the input-associated mode, this holds for any location that has not been written since it was last read.
- R7: `host_erase` at `host_loc`=x invalidates connection word x; it takes priority over a simultaneous `host_wr`. After one full frame, the affected output slot carries `IDLE_BYTE`, and other connections are unchanged.
- R8: The switch is non-blocking: all SLOTS output slots may be connected at once under any permutation, including the full slot reversal j <- SLOTS-1-j.
- R9: The byte for output slot j appears on `dout` in the clock cycle immediately after the cycle in which slot j is presented on `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one time slot per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_in_assoc | input | 1 | Static mode: 0 output-associated, 1 input-associated |
| fsync | input | 1 | Marks the current cycle as slot 0 |
| din | input | WIDTH | Incoming slot byte |
| dout | output | WIDTH | Outgoing slot byte, one cycle after its slot |
| host_wr | input | 1 | Write connection word `host_loc` with `host_word` and mark it valid |
| host_erase | input | 1 | Invalidate connection word `host_loc` |
| host_loc | input | $clog2(SLOTS) | Connection word index |
| host_word | input | $clog2(SLOTS) | Slot number stored in the connection word |

## Verification
Both modes are tried with a forward connection (4 to 6), a backward connection (6 to 5), and a same-slot connection (9 to 9). Between them, these three show the same-frame delay, the next-frame delay, and the read-before-write order. The full slot reversal connects every slot at once, which exposes address mix-ups and blocking that a single connection would hide. Erasing one connection while a neighbour stays up separates a targeted disconnect from a global one. A frame cut short by an early `fsync` shows whether the counter realigns or simply keeps counting; frames sent without `fsync` exercise the counter's own wrap.

// File: rtl/tsi_pkg.sv
// Shared declarations for the time-slot interchanger.
// Assumes: nothing beyond the standard language.
package tsi_pkg;

    // Which memory access follows the control words.
    typedef enum logic {
        MODE_OUT_ASSOC = 1'b0,   // sequential write, controlled read
        MODE_IN_ASSOC  = 1'b1    // controlled write, sequential read
    } tsi_mode_e;

endpackage

// File: rtl/tsi_slot_counter.sv
// Time-slot counter. It gives the current slot number for the cycle.
// The register holds the slot expected next; a high fsync overrides it with 0.
// Assumes: SLOTS >= 2, one slot per clock.
module tsi_slot_counter #(
    parameter int SLOTS = 32,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fsync,
    output logic [SW-1:0] slot
);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    logic [SW-1:0] cnt_q;

    // Current slot: frame sync forces slot 0.
    assign slot = fsync ? '0 : cnt_q;

    // Advance to the following slot, wrapping at the end of a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (slot == LAST)
            cnt_q <= '0;
        else
            cnt_q <= slot + SW'(1);
    end

    // R2: a synced cycle is slot 0, so slot 1 follows
    assert_sync_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> cnt_q == SW'(1));
    // R2: the last slot wraps to 0 without sync
    assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsync && cnt_q == LAST) |=> cnt_q == '0);
    // R2: slot numbers never leave the frame
    assert_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/tsi_ctrl_mem.sv
// Control (connection) memory: one word per slot, each with a valid flag.
// The host writes and erases words; the switch reads the word for the current slot.
// Assumes: host writes with an index or value beyond the frame are dropped.
module tsi_ctrl_mem #(
    parameter int SLOTS = 32,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_erase,
    input  logic [SW-1:0] host_loc,
    input  logic [SW-1:0] host_word,
    input  logic [SW-1:0] rd_slot,
    output logic          rd_vld,
    output logic [SW-1:0] rd_word
);
    localparam logic [SW:0] NSL = (SW + 1)'(SLOTS);

    logic [SLOTS-1:0] vld_q;
    logic [SW-1:0]    word_q [SLOTS];
    logic             loc_ok;
    logic             word_ok;

    // Range checks on the host request.
    assign loc_ok  = {1'b0, host_loc}  < NSL;
    assign word_ok = {1'b0, host_word} < NSL;

    // Read port for the current slot.
    assign rd_vld  = vld_q[rd_slot];
    assign rd_word = word_q[rd_slot];

    // Valid flags: reset clears all, erase wins over write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (host_erase && loc_ok)
            vld_q[host_loc] <= 1'b0;
        else if (host_wr && loc_ok && word_ok)
            vld_q[host_loc] <= 1'b1;
    end

    // Word storage: written with each accepted connect request.
    always_ff @(posedge clk) begin
        if (host_wr && !host_erase && loc_ok && word_ok)
            word_q[host_loc] <= host_word;
    end

    // R7: an erase leaves the word invalid
    assert_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_erase && loc_ok) |=> !vld_q[$past(host_loc)]);
    // R3: an in-range connect leaves the word valid
    assert_connect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_erase && loc_ok && word_ok) |=> vld_q[$past(host_loc)]);
endmodule

// File: rtl/tsi_speech_mem.sv
// Speech memory: one sample per slot, plus a "fresh" flag per location.
// A write sets the flag; a read with rclr clears it unless the same location is written.
// Reads are combinational and return the contents from before this cycle's write.
// Assumes: addresses are below SLOTS.
module tsi_speech_mem #(
    parameter int SLOTS = 32,
    parameter int WIDTH = 8,
    parameter int SW    = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [SW-1:0]    raddr,
    input  logic             rclr,
    output logic [WIDTH-1:0] rdata,
    output logic             rfresh
);
    logic [WIDTH-1:0] mem_q [SLOTS];
    logic [SLOTS-1:0] fresh_q;

    // Read port, old contents (read before write).
    assign rdata  = mem_q[raddr];
    assign rfresh = fresh_q[raddr];

    // Sample storage.
    always_ff @(posedge clk) begin
        if (we)
            mem_q[waddr] <= wdata;
    end

    // Fresh flags, one per location; a write overrides a clearing read.
    for (genvar i = 0; i < SLOTS; i++) begin : g_fresh
        always_ff @(posedge clk) begin
            if (!rst_n)
                fresh_q[i] <= 1'b0;
            else if (we && waddr == SW'(i))
                fresh_q[i] <= 1'b1;
            else if (rclr && raddr == SW'(i))
                fresh_q[i] <= 1'b0;
        end
    end

    // R6: a read-and-clear without a write to the same place leaves it stale
    assert_consume_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rclr && !(we && waddr == raddr)) |=> !fresh_q[$past(raddr)]);
    // R5: a written location is fresh on the next cycle
    assert_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> fresh_q[$past(waddr)]);
endmodule

// File: rtl/tsi_switch.sv
// Time-slot interchanger for one PCM highway, one slot per clock.
// It steers the speech and control memories by mode. The output byte is
// registered, so dout carries slot j in the cycle after slot j's input.
// Assumes: mode_in_assoc changes only while rst_n is low.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int               SLOTS     = 32,
    parameter int               WIDTH     = 8,
    parameter logic [WIDTH-1:0] IDLE_BYTE = 8'hD5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_in_assoc,
    input  logic                     fsync,
    input  logic [WIDTH-1:0]         din,
    output logic [WIDTH-1:0]         dout,
    input  logic                     host_wr,
    input  logic                     host_erase,
    input  logic [$clog2(SLOTS)-1:0] host_loc,
    input  logic [$clog2(SLOTS)-1:0] host_word
);
    localparam int SW = $clog2(SLOTS);

    tsi_mode_e        mode;
    logic [SW-1:0]    slot;
    logic             cm_vld;
    logic [SW-1:0]    cm_word;
    logic             sm_we;
    logic [SW-1:0]    sm_waddr;
    logic [SW-1:0]    sm_raddr;
    logic             sm_rclr;
    logic [WIDTH-1:0] sm_rdata;
    logic             sm_fresh;
    logic             out_ok;
    logic [WIDTH-1:0] dout_q;

    // Decode the static mode pin.
    assign mode = mode_in_assoc ? MODE_IN_ASSOC : MODE_OUT_ASSOC;

    tsi_slot_counter #(.SLOTS(SLOTS), .SW(SW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .fsync (fsync),
        .slot  (slot)
    );

    tsi_ctrl_mem #(.SLOTS(SLOTS), .SW(SW)) u_cm (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_erase (host_erase),
        .host_loc   (host_loc),
        .host_word  (host_word),
        .rd_slot    (slot),
        .rd_vld     (cm_vld),
        .rd_word    (cm_word)
    );

    // Steer the speech memory ports by mode.
    always_comb begin
        if (mode == MODE_IN_ASSOC) begin
            sm_we    = cm_vld;
            sm_waddr = cm_word;
            sm_raddr = slot;
            sm_rclr  = 1'b1;
            out_ok   = sm_fresh;
        end else begin
            sm_we    = 1'b1;
            sm_waddr = slot;
            sm_raddr = cm_word;
            sm_rclr  = 1'b0;
            out_ok   = cm_vld;
        end
    end

    tsi_speech_mem #(.SLOTS(SLOTS), .WIDTH(WIDTH), .SW(SW)) u_sm (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (sm_we),
        .waddr  (sm_waddr),
        .wdata  (din),
        .raddr  (sm_raddr),
        .rclr   (sm_rclr),
        .rdata  (sm_rdata),
        .rfresh (sm_fresh)
    );

    // Output register: the switched sample, or idle when unconnected.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout_q <= IDLE_BYTE;
        else if (out_ok)
            dout_q <= sm_rdata;
        else
            dout_q <= IDLE_BYTE;
    end

    assign dout = dout_q;

    // R1: reset forces the idle byte
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> dout == IDLE_BYTE);
    // R6: an unconnected output slot emits idle in the output-associated mode
    assert_unconnected_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OUT_ASSOC && !cm_vld) |=> dout == IDLE_BYTE);
    // R9: a connected slot's stored sample appears one cycle later
    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_ok |=> dout == $past(sm_rdata));
endmodule

// File: tb/tb_tsi_switch.sv
// Directed bench for tsi_switch: one task per scenario, each checks its own results.
module tb_tsi_switch;
    localparam int         SL   = 32;
    localparam int         W    = 8;
    localparam logic [7:0] IDLE = 8'hD5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_in_assoc = 1'b0;
    logic         fsync = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         host_wr = 1'b0;
    logic         host_erase = 1'b0;
    logic [4:0]   host_loc = '0;
    logic [4:0]   host_word = '0;

    tsi_switch #(.SLOTS(SL), .WIDTH(W), .IDLE_BYTE(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .mode_in_assoc(mode_in_assoc), .fsync(fsync),
        .din(din), .dout(dout), .host_wr(host_wr), .host_erase(host_erase),
        .host_loc(host_loc), .host_word(host_word)
    );

    always #5 clk = ~clk;

    int         checks = 0;
    int         fails = 0;
    int         salt = 0;
    logic [7:0] hist [0:7][0:SL-1];
    int         pf = 0;
    int         ps = 0;
    bit         pv = 1'b0;

    // Sample byte for frame f, slot s of the current run.
    function automatic logic [7:0] dat(int f, int s);
        return 8'((f * SL + s) * 7 + 3 + salt);
    endfunction

    // Expected output of slot j in frame f when fed from slot k.
    function automatic logic [7:0] expv(int f, int k, int j);
        return (j > k) ? dat(f, k) : dat(f - 1, k);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic sample_prev();
        if (pv) hist[pf][ps] = dout;
    endtask

    task automatic drive_frame(int f, int n, bit sync);
        for (int s = 0; s < n; s++) begin
            @(negedge clk);
            sample_prev();
            din = dat(f, s);
            fsync = sync && (s == 0);
            pf = f; ps = s; pv = 1'b1;
        end
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        sample_prev();
        pv = 1'b0; fsync = 1'b0; din = '0;
    endtask

    task automatic host_op(bit erase, int loc, int word);
        idle_cycle();
        host_wr = !erase; host_erase = erase;
        host_loc = 5'(loc); host_word = 5'(word);
        @(negedge clk);
        host_wr = 1'b0; host_erase = 1'b0;
    endtask

    task automatic do_reset(bit m);
        @(negedge clk);
        rst_n = 1'b0; mode_in_assoc = m; pv = 1'b0; fsync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        salt = salt + 41;
    endtask

    // R1: after reset nothing is connected.
    task automatic t_reset();
        do_reset(1'b0);
        check("R1 dout at reset", dout, IDLE);
        drive_frame(0, SL, 1'b1);
        idle_cycle();
        for (int j = 0; j < SL; j++) check("R1 unconnected after reset", hist[0][j], IDLE);
    endtask

    // Forward, backward and same-slot connections in either mode.
    task automatic t_basic(bit m);
        string rq;
        rq = m ? "R4" : "R3";
        do_reset(m);
        if (m) begin
            host_op(1'b0, 4, 6); host_op(1'b0, 6, 5); host_op(1'b0, 9, 9);
        end else begin
            host_op(1'b0, 6, 4); host_op(1'b0, 5, 6); host_op(1'b0, 9, 9);
        end
        drive_frame(0, SL, 1'b1);
        drive_frame(1, SL, 1'b0);
        drive_frame(2, SL, 1'b0);
        idle_cycle();
        check({rq, " slot4 to slot6 same frame"}, hist[1][6], dat(1, 4));
        check("R9 slot6 byte in cycle after slot6", hist[2][6], dat(2, 4));
        check("R5 slot6 to slot5 next frame", hist[2][5], dat(1, 6));
        check("R5 same slot gives previous frame", hist[2][9], dat(1, 9));
        check("R6 unconnected slot7 idle", hist[2][7], IDLE);
        check("R2 wrap without fsync", hist[2][0], IDLE);
    endtask

    // R7: erase one connection, keep the other.
    task automatic t_erase(bit m);
        if (m) host_op(1'b1, 4, 0); else host_op(1'b1, 6, 0);
        drive_frame(0, SL, 1'b1);
        drive_frame(1, SL, 1'b0);
        drive_frame(2, SL, 1'b0);
        idle_cycle();
        check("R7 erased slot6 idle", hist[1][6], IDLE);
        check("R7 erased slot6 stays idle", hist[2][6], IDLE);
        check("R7 other connection kept", hist[2][5], dat(1, 6));
    endtask

    // R8: full reversal, every slot connected at once.
    task automatic t_perm(bit m);
        do_reset(m);
        for (int j = 0; j < SL; j++) host_op(1'b0, j, SL - 1 - j);
        drive_frame(0, SL, 1'b1);
        drive_frame(1, SL, 1'b0);
        drive_frame(2, SL, 1'b0);
        idle_cycle();
        for (int j = 0; j < SL; j++)
            check("R8 reversal slot", hist[2][j], expv(2, SL - 1 - j, j));
    endtask

    // R2: an early fsync realigns the counter.
    task automatic t_realign();
        do_reset(1'b0);
        host_op(1'b0, 6, 4);
        drive_frame(0, SL, 1'b1);
        drive_frame(1, 12, 1'b0);
        drive_frame(2, SL, 1'b1);
        drive_frame(3, SL, 1'b0);
        idle_cycle();
        check("R2 realigned frame slot6", hist[2][6], dat(2, 4));
        check("R2 realigned next frame slot6", hist[3][6], dat(3, 4));
        check("R2 realigned slot18 idle", hist[2][18], IDLE);
    endtask

    bit done = 1'b0;

    initial begin
        t_reset();
        t_basic(1'b0);
        t_erase(1'b0);
        t_perm(1'b0);
        t_realign();
        t_basic(1'b1);
        t_erase(1'b1);
        t_perm(1'b1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule